// File: doc/BRIEF.md
# Configurable UART Serial Framer

This block is the bit-level engine of an asynchronous serial port. A transmit half takes one character at a time through a valid/ready pair and shifts it out on the line. Each character goes out as a low start bit, five to eight data bits (least significant first), an optional parity bit and a stop period at the high level. A receive half watches the incoming line with a 16-times-oversampled bit clock and takes each bit at its centre. It hands back the character as a one-cycle pulse, together with parity-error, framing-error and break flags.

One control byte sets the character shape for both halves. It covers data length, stop-bit count, parity enable, even or odd parity, and stick parity, and it also carries a request to hold the transmit line low (a break). A 16-bit divisor sets the bit rate: one oversample tick every `divisor` clocks, sixteen ticks per bit. Address decoding, FIFOs and interrupt generation sit outside and connect through the ports below. Each half captures the framing fields at the start of a character, so a change to the control byte takes effect at the next character.

Top module: `serial_framer`

## Requirements
- R1: Data length is 5 + line_ctl[1:0]. The transmitter sends a 0 start bit and then that many data bits, LSB first. A received character is right-aligned in rx_data, and its bits above the length read 0.
- R2: With line_ctl[2]=0 the stop period is one bit (16 ticks). With line_ctl[2]=1 it is 24 ticks for 5-bit data and 32 ticks otherwise. With divisor 1, one frame lasts 16*(1+length+parity) + stop ticks clocks, counted from the accepting edge to tx_ready returning.
- R3: line_ctl[3]=1 inserts a parity bit after the data. line_ctl[4]=1 selects even parity (data ones plus parity bit is even) and 0 selects odd. The receiver raises rx_parity_err when the received parity bit differs from the expected one, and never raises it when parity is off.
- R4: With line_ctl[3]=1 and line_ctl[5]=1 (stick), the parity bit is the constant NOT line_ctl[4], both when sending and when checking.
- R5: While line_ctl[6]=1, tx_line is 0 from the cycle after it is seen and tx_ready is 0. A character in progress is abandoned. A receiver reading the corrupted frame sees rx_frame_err=1. Once the bit clears, the line returns high and tx_ready returns to 1.
- R6: One bit lasts 16*divisor clocks. A divisor of 0 behaves as 1.
- R7: A start bit that reads high at its midpoint (tick 8 of the bit) is discarded, and no character is delivered.
- R8: When the first stop bit samples low, rx_frame_err=1 and the data bits are still delivered. The error flags are only ever 1 together with rx_valid, and rx_valid lasts one cycle.
- R9: A line held low for a whole frame is delivered once as rx_data=0 with rx_frame_err=1 and rx_break=1. No further character is delivered until the line has gone high again.
- R10: line_ctl[7] has no effect on framing, timing or received data.
- R11: After reset tx_line=1, tx_ready=1 and rx_valid=0. While tx_ready stays 1, tx_line stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_ctl | input | 8 | Framing control byte (length, stop, parity, stick, break, spare bit 7) |
| divisor | input | 16 | Clocks per oversample tick |
| tx_data | input | 8 | Character to send |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Transmitter idle and able to accept |
| tx_line | output | 1 | Serial output, idle high |
| rx_line | input | 1 | Serial input, asynchronous |
| rx_data | output | 8 | Received character, right-aligned |
| rx_valid | output | 1 | One-cycle pulse with a received character |
| rx_parity_err | output | 1 | Parity mismatch on the delivered character |
| rx_frame_err | output | 1 | Stop bit sampled low on the delivered character |
| rx_break | output | 1 | Delivered character was a held-low line |

## Verification
The hardest case to reach from the ports is a break that cuts into a frame already on the line. The receiver then has a partly valid character in its shifter and must end with a framing error, then sit out the rest of the low period without emitting more characters. The bench loops the transmit line back into the receiver, starts a character and raises the break bit part-way through. It then counts deliveries over a window much longer than a frame. A malformed start, a low stop bit and wrong parity cannot come from the transmitter, so the bench drives those bit by bit on its own copy of the line.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

    localparam int CHAR_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PARITY,
        PH_STOP,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        logic [1:0] len_sel;
        logic       multi_stop;
        logic       par_en;
        logic       par_even;
        logic       par_stick;
    } frame_cfg_t;

    function automatic frame_cfg_t decode_cfg(input logic [5:0] c);
        frame_cfg_t f;
        f.len_sel    = c[1:0];
        f.multi_stop = c[2];
        f.par_en     = c[3];
        f.par_even   = c[4];
        f.par_stick  = c[5];
        return f;
    endfunction

    // index of the last data bit: length - 1
    function automatic logic [2:0] last_bit_idx(input frame_cfg_t f);
        return 3'(3'd4 + {1'b0, f.len_sel});
    endfunction

    function automatic logic [CHAR_W-1:0] len_mask(input frame_cfg_t f);
        return 8'hFF >> (2'd3 - f.len_sel);
    endfunction

    function automatic logic parity_bit(input frame_cfg_t f, input logic [CHAR_W-1:0] d);
        logic [CHAR_W-1:0] m;
        m = d & len_mask(f);
        if (f.par_stick) return ~f.par_even;
        if (f.par_even)  return ^m;
        return ~(^m);
    endfunction

endpackage

// File: rtl/sfr_baud.sv
module sfr_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } baud_st_t;

    baud_st_t q, d;
    logic [DIV_W:0] cnt_inc;
    logic           wrap;

    always_comb begin
        d       = q;
        cnt_inc = {1'b0, q.cnt} + 1'b1;
        // zero and one both wrap every clock
        wrap    = cnt_inc >= {1'b0, divisor};
        d.cnt   = wrap ? '0 : cnt_inc[DIV_W-1:0];
        d.tick  = wrap;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tick = q.tick;

endmodule

// File: rtl/sfr_tx.sv
module sfr_tx
    import sfr_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              brk,
    input  frame_cfg_t        cfg,
    input  logic [CHAR_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              tx_line
);

    localparam int CNT_W = $clog2(OVERSAMPLE * 2);
    localparam logic [CNT_W-1:0] BIT_LAST    = CNT_W'(OVERSAMPLE - 1);
    localparam logic [CNT_W-1:0] STOP15_LAST = CNT_W'(OVERSAMPLE * 3 / 2 - 1);
    localparam logic [CNT_W-1:0] STOP2_LAST  = CNT_W'(OVERSAMPLE * 2 - 1);

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        logic [CHAR_W-1:0] shreg;
        logic [2:0]        bitidx;
        frame_cfg_t        cfg;
        logic              par;
        logic              line;
    } tx_st_t;

    tx_st_t q, d;
    logic [CNT_W-1:0] stop_last;
    logic             unused_tx;

    assign unused_tx = q.cfg.par_even ^ q.cfg.par_stick;

    always_comb begin
        if (!q.cfg.multi_stop)         stop_last = BIT_LAST;
        else if (q.cfg.len_sel == 2'd0) stop_last = STOP15_LAST;
        else                           stop_last = STOP2_LAST;
    end

    always_comb begin
        d        = q;
        tx_ready = (q.phase == PH_IDLE) && !brk;
        if (brk) begin
            d.phase = PH_IDLE;
            d.cnt   = '0;
        end else begin
            unique case (q.phase)
                PH_IDLE: begin
                    if (tx_valid) begin
                        d.phase  = PH_START;
                        d.cnt    = '0;
                        d.shreg  = tx_data;
                        d.bitidx = '0;
                        d.cfg    = cfg;
                        d.par    = parity_bit(cfg, tx_data);
                    end
                end
                PH_START: begin
                    if (tick) begin
                        if (q.cnt == BIT_LAST) begin
                            d.phase = PH_DATA;
                            d.cnt   = '0;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                PH_DATA: begin
                    if (tick) begin
                        if (q.cnt == BIT_LAST) begin
                            d.cnt   = '0;
                            d.shreg = q.shreg >> 1;
                            if (q.bitidx == last_bit_idx(q.cfg))
                                d.phase = q.cfg.par_en ? PH_PARITY : PH_STOP;
                            else
                                d.bitidx = q.bitidx + 1'b1;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                PH_PARITY: begin
                    if (tick) begin
                        if (q.cnt == BIT_LAST) begin
                            d.phase = PH_STOP;
                            d.cnt   = '0;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                PH_STOP: begin
                    if (tick) begin
                        if (q.cnt == stop_last) begin
                            d.phase = PH_IDLE;
                            d.cnt   = '0;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                default: d.phase = PH_IDLE;
            endcase
        end

        // line level for the phase being entered
        if (brk) begin
            d.line = 1'b0;
        end else begin
            unique case (d.phase)
                PH_START:  d.line = 1'b0;
                PH_DATA:   d.line = d.shreg[0];
                PH_PARITY: d.line = d.par;
                default:   d.line = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.line <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign tx_line = q.line;

endmodule

// File: rtl/sfr_rx.sv
module sfr_rx
    import sfr_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  frame_cfg_t        cfg,
    input  logic              rx_line,
    output logic [CHAR_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_parity_err,
    output logic              rx_frame_err,
    output logic              rx_break
);

    localparam int CNT_W = $clog2(OVERSAMPLE * 2);
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(OVERSAMPLE - 1);
    localparam logic [CNT_W-1:0] MID_LAST = CNT_W'(OVERSAMPLE / 2 - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        phase_e                 phase;
        logic [CNT_W-1:0]       cnt;
        logic [CHAR_W-1:0]      shreg;
        logic [2:0]             bitidx;
        frame_cfg_t             cfg;
        logic                   par_seen;
        logic                   o_valid;
        logic [CHAR_W-1:0]      o_data;
        logic                   o_perr;
        logic                   o_ferr;
        logic                   o_brk;
    } rx_st_t;

    rx_st_t q, d;
    logic              line_s;
    logic [CHAR_W-1:0] aligned;
    logic              unused_rx;

    assign line_s    = q.sync[SYNC_STAGES-1];
    assign aligned   = q.shreg >> (2'd3 - q.cfg.len_sel);
    assign unused_rx = q.cfg.multi_stop;

    always_comb begin
        d         = q;
        d.sync    = {q.sync[SYNC_STAGES-2:0], rx_line};
        d.o_valid = 1'b0;
        d.o_perr  = 1'b0;
        d.o_ferr  = 1'b0;
        d.o_brk   = 1'b0;
        unique case (q.phase)
            PH_IDLE: begin
                if (!line_s) begin
                    d.phase  = PH_START;
                    d.cnt    = '0;
                    d.bitidx = '0;
                    d.shreg  = '0;
                    d.cfg    = cfg;
                end
            end
            PH_START: begin
                if (tick) begin
                    if (q.cnt == MID_LAST) begin
                        d.cnt   = '0;
                        d.phase = line_s ? PH_IDLE : PH_DATA;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            PH_DATA: begin
                if (tick) begin
                    if (q.cnt == BIT_LAST) begin
                        d.cnt   = '0;
                        d.shreg = {line_s, q.shreg[CHAR_W-1:1]};
                        if (q.bitidx == last_bit_idx(q.cfg))
                            d.phase = q.cfg.par_en ? PH_PARITY : PH_STOP;
                        else
                            d.bitidx = q.bitidx + 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            PH_PARITY: begin
                if (tick) begin
                    if (q.cnt == BIT_LAST) begin
                        d.cnt      = '0;
                        d.par_seen = line_s;
                        d.phase    = PH_STOP;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            PH_STOP: begin
                if (tick) begin
                    if (q.cnt == BIT_LAST) begin
                        d.cnt     = '0;
                        d.o_valid = 1'b1;
                        d.o_data  = aligned;
                        d.o_perr  = q.cfg.par_en && (q.par_seen != parity_bit(q.cfg, aligned));
                        d.o_ferr  = !line_s;
                        d.o_brk   = !line_s && (aligned == '0) && !(q.cfg.par_en && q.par_seen);
                        d.phase   = line_s ? PH_IDLE : PH_HOLD;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            PH_HOLD: begin
                if (line_s) d.phase = PH_IDLE;
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.sync <= '1;
        end else begin
            q <= d;
        end
    end

    assign rx_data       = q.o_data;
    assign rx_valid      = q.o_valid;
    assign rx_parity_err = q.o_perr;
    assign rx_frame_err  = q.o_ferr;
    assign rx_break      = q.o_brk;

endmodule

// File: rtl/serial_framer.sv
module serial_framer
    import sfr_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        line_ctl,
    input  logic [DIV_W-1:0]  divisor,
    input  logic [CHAR_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              tx_line,
    input  logic              rx_line,
    output logic [CHAR_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_parity_err,
    output logic              rx_frame_err,
    output logic              rx_break
);

    frame_cfg_t cfg;
    logic       tick;
    logic       unused_ctl;

    assign cfg        = decode_cfg(line_ctl[5:0]);
    // bit 7 is a register-access flag for the host side only
    assign unused_ctl = line_ctl[7];

    sfr_baud #(.DIV_W(DIV_W)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .divisor (divisor),
        .tick    (tick)
    );

    sfr_tx #(.OVERSAMPLE(OVERSAMPLE)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .brk      (line_ctl[6]),
        .cfg      (cfg),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .tx_line  (tx_line)
    );

    sfr_rx #(.OVERSAMPLE(OVERSAMPLE), .SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .cfg           (cfg),
        .rx_line       (rx_line),
        .rx_data       (rx_data),
        .rx_valid      (rx_valid),
        .rx_parity_err (rx_parity_err),
        .rx_frame_err  (rx_frame_err),
        .rx_break      (rx_break)
    );

endmodule

// File: rtl/serial_framer_chk.sv
module serial_framer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       brk_req,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       tx_line,
    input logic [7:0] rx_data,
    input logic       rx_valid,
    input logic       rx_parity_err,
    input logic       rx_frame_err,
    input logic       rx_break
);

    AST_BREAK_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(brk_req) |-> !tx_line); // R5

    AST_ACCEPT_SENDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready |=> !tx_line); // R1

    AST_IDLE_STAYS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready && $past(tx_ready) |-> tx_line); // R11

    AST_FLAGS_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_parity_err || rx_frame_err || rx_break) |-> rx_valid); // R8

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R8

    AST_BREAK_ZERO_FRAMED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_break |-> rx_frame_err && (rx_data == 8'h00)); // R9

endmodule

bind serial_framer serial_framer_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .brk_req       (line_ctl[6]),
    .tx_valid      (tx_valid),
    .tx_ready      (tx_ready),
    .tx_line       (tx_line),
    .rx_data       (rx_data),
    .rx_valid      (rx_valid),
    .rx_parity_err (rx_parity_err),
    .rx_frame_err  (rx_frame_err),
    .rx_break      (rx_break)
);

// File: tb/serial_framer_test.sv
`timescale 1ns/1ps
module serial_framer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  line_ctl = 8'h03;
    logic [15:0] divisor = 16'd1;
    logic [7:0]  tx_data = 8'h00;
    logic        tx_valid = 1'b0;
    logic        tx_ready, tx_line;
    logic        bench_rx = 1'b1;
    logic        loop_en = 1'b1;
    logic        rx_line;
    logic [7:0]  rx_data;
    logic        rx_valid, rx_parity_err, rx_frame_err, rx_break;

    int total = 0;
    int failed = 0;
    int got_cnt = 0;
    logic [7:0] got_data = 8'h00;
    logic got_perr = 1'b0, got_ferr = 1'b0, got_brk = 1'b0;

    always #2 clk = ~clk;

    assign rx_line = loop_en ? tx_line : bench_rx;

    serial_framer uut (
        .clk(clk), .rst_n(rst_n), .line_ctl(line_ctl), .divisor(divisor),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_line(tx_line),
        .rx_line(rx_line), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err), .rx_break(rx_break)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            got_cnt  <= got_cnt + 1;
            got_data <= rx_data;
            got_perr <= rx_parity_err;
            got_ferr <= rx_frame_err;
            got_brk  <= rx_break;
        end
    end

    task automatic check(input string req, input int act, input int expv);
        total++;
        if (act != expv) begin
            failed++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic int nbits(input logic [7:0] c);
        return 5 + int'(c[1:0]);
    endfunction

    function automatic logic exp_par(input logic [7:0] c, input logic [7:0] dv);
        logic [7:0] m;
        m = dv & 8'(('h1 << nbits(c)) - 1);
        if (c[5]) return ~c[4];
        if (c[4]) return ^m;
        return ~(^m);
    endfunction

    function automatic int exp_len(input logic [7:0] c);
        int stop;
        stop = !c[2] ? 16 : (nbits(c) == 5 ? 24 : 32);
        return 16 * (1 + nbits(c) + int'(c[3])) + stop;
    endfunction

    // offer one character and follow the frame until tx_ready returns
    task automatic send_frame(input logic [7:0] dv, input int div,
                              output int len, output logic [11:0] cap);
        int k;
        cap = '1;
        @(negedge clk);
        tx_data  = dv;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        k = 0;
        while (!tx_ready && k < 4000) begin
            if ((k % (16 * div)) == 8 * div && (k / (16 * div)) < 12)
                cap[k / (16 * div)] = tx_line;
            k++;
            @(negedge clk);
        end
        len = k;
        repeat (30) @(negedge clk);
    endtask

    task automatic drive_bits(input logic [15:0] bits, input int n);
        for (int i = 0; i < n; i++) begin
            bench_rx = bits[i];
            repeat (16) @(negedge clk);
        end
        bench_rx = 1'b1;
        repeat (40) @(negedge clk);
    endtask

    localparam int NVEC = 13;
    // {control byte, data byte}
    localparam logic [15:0] VECS [NVEC] = '{
        16'h03A5, 16'h00A5, 16'h013C, 16'h02FF, 16'h0761, 16'h0455, 16'h0B61,
        16'h1B61, 16'h2B61, 16'h3B61, 16'h1813, 16'h0F80, 16'h835A
    };

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        failed++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        int len, base, nb;
        logic [11:0] cap;
        logic [7:0] dv, c, got_bits;

        repeat (5) @(negedge clk);
        check("R11 reset tx_line", int'(tx_line), 1);
        check("R11 reset tx_ready", int'(tx_ready), 1);
        check("R11 reset rx_valid", int'(rx_valid), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R11 idle line after reset", int'(tx_line), 1);

        for (int i = 0; i < NVEC; i++) begin
            c  = VECS[i][15:8];
            dv = VECS[i][7:0];
            nb = nbits(c);
            line_ctl = c;
            base = got_cnt;
            send_frame(dv, 1, len, cap);
            got_bits = '0;
            for (int b = 0; b < nb; b++) got_bits[b] = cap[1 + b];
            check("R1 start bit", int'(cap[0]), 0);
            check("R1 data bits sent", int'(got_bits), int'(dv & 8'((1 << nb) - 1)));
            if (c[3])
                check(c[5] ? "R4 stick parity sent" : "R3 parity sent",
                      int'(cap[1 + nb]), int'(exp_par(c, dv)));
            check("R2 first stop bit", int'(cap[1 + nb + int'(c[3])]), 1);
            check("R2 frame length", len, exp_len(c));
            check("R1 one char received", got_cnt - base, 1);
            check("R1 received data masked", int'(got_data), int'(dv & 8'((1 << nb) - 1)));
            check("R3 no parity error loopback", int'(got_perr), 0);
            if (c[7]) begin
                check("R10 spare bit frame length", len, exp_len(8'h03));
                check("R10 spare bit data", int'(got_data), int'(dv));
            end
        end

        // divisor 3: three clocks per tick
        line_ctl = 8'h03;
        divisor  = 16'd3;
        base = got_cnt;
        send_frame(8'h3C, 3, len, cap);
        check("R6 divisor 3 frame length", (len >= 480 - 2 && len <= 480) ? 1 : 0, 1);
        check("R6 divisor 3 data on line", int'(cap[8:1]), 8'h3C);
        check("R6 divisor 3 received", int'(got_data), 8'h3C);
        divisor = 16'd0;
        send_frame(8'hC3, 1, len, cap);
        check("R6 divisor 0 acts as 1", len, 160);
        divisor = 16'd1;

        // break raised while a character is on the line
        base = got_cnt;
        @(negedge clk);
        tx_data = 8'h41;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        repeat (40) @(negedge clk);
        line_ctl = 8'h43;
        @(negedge clk);
        check("R5 break drives line low", int'(tx_line), 0);
        check("R5 break holds tx_ready low", int'(tx_ready), 0);
        repeat (400) @(negedge clk);
        check("R5 line still low in break", int'(tx_line), 0);
        check("R5 corrupted frame delivered once", got_cnt - base, 1);
        check("R5 corrupted frame flagged", int'(got_ferr), 1);
        line_ctl = 8'h03;
        repeat (2) @(negedge clk);
        check("R5 line high after break", int'(tx_line), 1);
        check("R5 ready after break", int'(tx_ready), 1);
        repeat (40) @(negedge clk);
        check("R5 nothing more after break", got_cnt - base, 1);

        // break from idle, loopback
        base = got_cnt;
        line_ctl = 8'h43;
        repeat (600) @(negedge clk);
        check("R9 one break char", got_cnt - base, 1);
        check("R9 break data zero", int'(got_data), 0);
        check("R9 break frame flag", int'(got_ferr), 1);
        check("R9 break flag", int'(got_brk), 1);
        line_ctl = 8'h03;
        repeat (40) @(negedge clk);
        send_frame(8'h24, 1, len, cap);
        check("R9 normal char after break", int'(got_data), 8'h24);
        check("R9 no break flag after", int'(got_brk), 0);

        // bench-driven line
        loop_en = 1'b0;
        bench_rx = 1'b1;
        repeat (10) @(negedge clk);
        base = got_cnt;
        bench_rx = 1'b0;
        repeat (5) @(negedge clk);
        bench_rx = 1'b1;
        repeat (300) @(negedge clk);
        check("R7 glitch rejected", got_cnt - base, 0);
        drive_bits({6'h3F, 1'b1, 8'h96, 1'b0}, 10);
        check("R7 char after glitch", int'(got_data), 8'h96);
        check("R8 clean stop no error", int'(got_ferr), 0);

        base = got_cnt;
        drive_bits({6'h3F, 1'b0, 8'h96, 1'b0}, 10);
        check("R8 framing error flagged", int'(got_ferr), 1);
        check("R8 data kept on framing error", int'(got_data), 8'h96);
        check("R8 not a break", int'(got_brk), 0);
        check("R8 single delivery", got_cnt - base, 1);

        line_ctl = 8'h0B; // 8 bits, odd parity
        drive_bits({5'h1F, 1'b1, 1'b1, 8'h61, 1'b0}, 11);
        check("R3 wrong parity detected", int'(got_perr), 1);
        drive_bits({5'h1F, 1'b1, 1'b0, 8'h61, 1'b0}, 11);
        check("R3 right parity accepted", int'(got_perr), 0);
        line_ctl = 8'h2B; // stick, expected parity 1
        drive_bits({5'h1F, 1'b1, 1'b0, 8'h61, 1'b0}, 11);
        check("R4 stick mismatch detected", int'(got_perr), 1);
        drive_bits({5'h1F, 1'b1, 1'b1, 8'h61, 1'b0}, 11);
        check("R4 stick match accepted", int'(got_perr), 0);
        line_ctl = 8'h00; // 5 bits, upper bits masked
        drive_bits({9'h1FF, 1'b1, 5'h1A, 1'b0}, 7);
        check("R1 5-bit receive", int'(got_data), 8'h1A);

        line_ctl = 8'h03;
        base = got_cnt;
        bench_rx = 1'b0;
        repeat (16 * 14) @(negedge clk);
        bench_rx = 1'b1;
        repeat (40) @(negedge clk);
        check("R9 driven break once", got_cnt - base, 1);
        check("R9 driven break flag", int'(got_brk), 1);
        check("R9 driven break data", int'(got_data), 0);

        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

endmodule